// File: doc/BRIEF.md
# Video Transfer Handshake Controller

This controller paces the movement of formatted video words from an accumulation stage into an output memory over a data bus that other traffic also uses. A falling edge on the active-low halt input starts a transfer. From then on the block moves a fixed number of words. The pace comes from a master tick, which is the block clock divided by a parameter. With the default of 4, a 5 MHz clock gives a 1.25 MHz tick.

A word is launched on a tick only when three conditions hold: the bus is free, the auxiliary (higher-priority) source is not holding the bus, and the producer has a word ready. For each launched word the active-low write strobe stays low for exactly one tick period, which tells the output memory that a word can be loaded. If the auxiliary source pulls its disable line low, no new word is launched until the line goes high again. Each word is still sent exactly once.

A separate latch records antenna-switch events for the processor. The latch holds its flag until the processor clears it with an active-low clear line. An interrupt reset from the processor sends all sequencing and latch state back to idle.

Top module: `vtx_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `wr_stb_n` is 1 and `xtn_det` is 0. While `busy` is 0, `wr_stb_n` stays 1.
- R2: A high-to-low change on `halt_n` while idle sets `busy` to 1 at the next clock edge. Holding `halt_n` low after a transfer ends does not start another one.
- R3: Each write-strobe pulse, with `wr_stb_n` low, lasts exactly DIV clock cycles, which is one master tick.
- R4: A transfer produces exactly WORDS strobe pulses. `busy` returns to 0 at the edge where the last pulse ends.
- R5: While `bus_avail` is 0, no new strobe pulse begins.
- R6: While `aux_dis_n` is 0, no new strobe pulse begins. When it returns to 1 the transfer resumes, and the total stays WORDS with no word lost or repeated.
- R7: While `word_rdy` is 0, no new strobe pulse begins.
- R8: The master tick is the clock divided by DIV, with its phase restarted at the start of each transfer. When no condition holds a word back, strobe pulses start every 2*DIV clock cycles.
- R9: A one-cycle high on `xtn_pulse` sets `xtn_det` to 1 at the next edge. The flag stays 1 until it is cleared.
- R10: `xtn_clr_n` low for a cycle clears `xtn_det` at the next edge. When `xtn_pulse` is high in the same cycle, the flag is set instead.
- R11: `cpu_rst` high for a cycle sets `busy` to 0, `wr_stb_n` to 1 and `xtn_det` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (5 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rst | input | 1 | Interrupt reset from the processor, active high, synchronous |
| halt_n | input | 1 | A falling edge starts a transfer |
| bus_avail | input | 1 | High while the shared bus may carry video words |
| aux_dis_n | input | 1 | Low while the auxiliary source holds the bus |
| word_rdy | input | 1 | High while a formatted word is available |
| xtn_pulse | input | 1 | One-cycle pulse on each antenna switch |
| xtn_clr_n | input | 1 | Active-low clear of the transition flag |
| wr_stb_n | output | 1 | Active-low write strobe, one tick per word |
| busy | output | 1 | High while a transfer is in progress |
| xtn_det | output | 1 | Latched antenna-transition flag |

## Verification
The assertions assume that every input is synchronous to `clk` and that `rst_n` stays low for several edges. A strobe-launch check compares the current strobe with the gating inputs one edge earlier, so the inputs must be stable at the sampling edge. The stimulus changes every input only on the falling clock edge. It applies the gating inputs and the auxiliary disable only while the strobe is high or across whole pause windows, so each pause starts from a known state.

// File: rtl/vtx_pkg.sv
// Package: shared types for the video transfer controller.
// Assumes nothing beyond being compiled before the modules that import it.
package vtx_pkg;

    // Sequencer states: idle, armed waiting for a tick, strobe active.
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ARM  = 2'd1,
        XS_STB  = 2'd2
    } xfer_st_t;

endpackage : vtx_pkg

// File: rtl/vtx_tick_div.sv
// Module: vtx_tick_div
// Divides the block clock by DIV to form the master transfer tick.
// The counter is held at zero while disabled, so the tick phase restarts
// at each transfer. Assumes DIV >= 2.
module vtx_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Advance the phase counter while enabled, wrap at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick marks the final cycle of each period.
    always_comb begin
        tick = en && (cnt == LAST);
    end

    // R8: a tick never occurs in two consecutive cycles.
    p_tick_spaced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick on consecutive cycles");

endmodule : vtx_tick_div

// File: rtl/vtx_xfer_seq.sv
// Module: vtx_xfer_seq
// Sequences one transfer of WORDS words. A falling halt_n edge arms the
// sequencer. On each tick, if bus, auxiliary source and producer allow it,
// a word is launched and its strobe is held low for one full tick period.
// Assumes all inputs are synchronous to clk.
module vtx_xfer_seq
    import vtx_pkg::*;
#(
    parameter int WORDS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rst,
    input  logic tick,
    input  logic halt_n,
    input  logic bus_avail,
    input  logic aux_dis_n,
    input  logic word_rdy,
    output logic busy,
    output logic wr_stb_n
);
    localparam int WCW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WORDS - 1);

    xfer_st_t       st, st_nx;
    logic [WCW-1:0] wcnt, wcnt_nx;
    logic           halt_q;
    logic           halt_fall;
    logic           launch_ok;

    // Remember the previous halt level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
        end else begin
            halt_q <= halt_n;
        end
    end

    // Decode the start event and the launch permission.
    always_comb begin
        halt_fall = halt_q && !halt_n;
        launch_ok = bus_avail && aux_dis_n && word_rdy;
    end

    // Next-state and word-count logic.
    always_comb begin
        st_nx   = st;
        wcnt_nx = wcnt;
        unique case (st)
            XS_IDLE: begin
                if (halt_fall) begin
                    st_nx   = XS_ARM;
                    wcnt_nx = '0;
                end
            end
            XS_ARM: begin
                if (tick && launch_ok) begin
                    st_nx = XS_STB;
                end
            end
            XS_STB: begin
                if (tick) begin
                    if (wcnt == WLAST) begin
                        st_nx   = XS_IDLE;
                        wcnt_nx = '0;
                    end else begin
                        st_nx   = XS_ARM;
                        wcnt_nx = wcnt + 1'b1;
                    end
                end
            end
            default: begin
                st_nx   = XS_IDLE;
                wcnt_nx = '0;
            end
        endcase
    end

    // State register with reset and processor interrupt reset.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_rst) begin
            st   <= XS_IDLE;
            wcnt <= '0;
        end else begin
            st   <= st_nx;
            wcnt <= wcnt_nx;
        end
    end

    // Output decode from the state register.
    always_comb begin
        busy     = (st != XS_IDLE);
        wr_stb_n = (st != XS_STB);
    end

    // R1: no strobe outside a transfer.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> wr_stb_n)
        else $error("strobe while idle");

    // R2: a halt falling edge while idle starts a transfer.
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && halt_q && !halt_n && !cpu_rst) |=> busy)
        else $error("halt edge did not start transfer");

    // R3: an active strobe is held until a tick ends it.
    p_stb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || cpu_rst)
        (!wr_stb_n && !tick) |=> !wr_stb_n)
        else $error("strobe ended early");

    // R4: busy only drops as the last strobe ends, or on interrupt reset.
    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!wr_stb_n || cpu_rst))
        else $error("busy dropped without final strobe");

    // R5: a strobe starts only if the bus was available.
    p_bus_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb_n) |-> $past(bus_avail))
        else $error("strobe launched without bus");

    // R6: a strobe starts only if the auxiliary source released the bus.
    p_aux_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb_n) |-> $past(aux_dis_n))
        else $error("strobe launched during auxiliary hold");

    // R7: a strobe starts only if a word was ready.
    p_word_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb_n) |-> $past(word_rdy))
        else $error("strobe launched without word");

    // R8: a strobe starts only on a master tick.
    p_tick_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb_n) |-> $past(tick))
        else $error("strobe launched off tick");

endmodule : vtx_xfer_seq

// File: rtl/vtx_xtn_latch.sv
// Module: vtx_xtn_latch
// Holds an antenna-transition flag until the processor clears it.
// A set and a clear in the same cycle leave the flag set, so no event is
// lost. Assumes xtn_pulse is synchronous to clk.
module vtx_xtn_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rst,
    input  logic xtn_pulse,
    input  logic xtn_clr_n,
    output logic xtn_det
);
    // Set on an event, clear on acknowledge, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_rst) begin
            xtn_det <= 1'b0;
        end else if (xtn_pulse) begin
            xtn_det <= 1'b1;
        end else if (!xtn_clr_n) begin
            xtn_det <= 1'b0;
        end
    end

    // R9: an event sets the flag.
    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xtn_pulse && !cpu_rst) |=> xtn_det)
        else $error("transition not latched");

    // R10: a clear with no event drops the flag.
    p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!xtn_clr_n && !xtn_pulse) |=> !xtn_det)
        else $error("transition flag not cleared");

    // R11: interrupt reset drops the flag.
    p_irst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |=> !xtn_det)
        else $error("flag survived interrupt reset");

endmodule : vtx_xtn_latch

// File: rtl/vtx_ctrl.sv
// Module: vtx_ctrl (top)
// Video transfer handshake controller: tick divider, transfer sequencer
// and antenna-transition latch. Assumes every input is synchronous to clk.
module vtx_ctrl #(
    parameter int DIV   = 4,
    parameter int WORDS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rst,
    input  logic halt_n,
    input  logic bus_avail,
    input  logic aux_dis_n,
    input  logic word_rdy,
    input  logic xtn_pulse,
    input  logic xtn_clr_n,
    output logic wr_stb_n,
    output logic busy,
    output logic xtn_det
);
    logic tick;

    vtx_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cpu_rst),
        .en    (busy),
        .tick  (tick)
    );

    vtx_xfer_seq #(.WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rst   (cpu_rst),
        .tick      (tick),
        .halt_n    (halt_n),
        .bus_avail (bus_avail),
        .aux_dis_n (aux_dis_n),
        .word_rdy  (word_rdy),
        .busy      (busy),
        .wr_stb_n  (wr_stb_n)
    );

    vtx_xtn_latch u_xtn (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rst   (cpu_rst),
        .xtn_pulse (xtn_pulse),
        .xtn_clr_n (xtn_clr_n),
        .xtn_det   (xtn_det)
    );

    // R11: interrupt reset returns the sequencer to idle.
    p_irst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |=> (!busy && wr_stb_n))
        else $error("transfer survived interrupt reset");

endmodule : vtx_ctrl

// File: tb/vtx_ctrl_bench.sv
// Directed bench for vtx_ctrl: one task per scenario, each checks itself.
module vtx_ctrl_bench;
    localparam int CLK_PERIOD = 200;
    localparam int DIV   = 4;
    localparam int WORDS = 8;

    logic clk = 1'b0;
    logic rst_n, cpu_rst, halt_n, bus_avail, aux_dis_n, word_rdy;
    logic xtn_pulse, xtn_clr_n;
    logic wr_stb_n, busy, xtn_det;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Strobe statistics gathered by the monitor.
    int pulses, minw, maxw, curw, last_start, ming, maxg;
    logic prev_stb = 1'b1;

    vtx_ctrl #(.DIV(DIV), .WORDS(WORDS)) u_vtx_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst), .halt_n(halt_n),
        .bus_avail(bus_avail), .aux_dis_n(aux_dis_n), .word_rdy(word_rdy),
        .xtn_pulse(xtn_pulse), .xtn_clr_n(xtn_clr_n),
        .wr_stb_n(wr_stb_n), .busy(busy), .xtn_det(xtn_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Measure strobe widths and start-to-start spacing at the falling edge.
    always @(negedge clk) begin
        if (!wr_stb_n) begin
            if (prev_stb) begin
                pulses = pulses + 1;
                if (last_start >= 0) begin
                    if (cyc - last_start < ming) ming = cyc - last_start;
                    if (cyc - last_start > maxg) maxg = cyc - last_start;
                end
                last_start = cyc;
                curw = 0;
            end
            curw = curw + 1;
        end else if (!prev_stb) begin
            if (curw < minw) minw = curw;
            if (curw > maxw) maxw = curw;
        end
        prev_stb = wr_stb_n;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        @(posedge clk);
        pulses = 0; minw = 1000; maxw = 0; last_start = -1;
        ming = 1000; maxg = 0;
    endtask

    task automatic start_xfer();
        @(negedge clk) halt_n = 1'b0;
        @(negedge clk) halt_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(wr_stb_n == 1'b1, "R1 wr_stb_n", wr_stb_n, 1);
        chk(xtn_det == 1'b0, "R1 xtn_det", xtn_det, 0);
    endtask

    task automatic t_basic();
        clear_stats();
        @(negedge clk) halt_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2 start", busy, 1);
        wait_idle();
        chk(pulses == WORDS, "R4 count", pulses, WORDS);
        chk(busy == 1'b0, "R4 busy end", busy, 0);
        chk(minw == DIV && maxw == DIV, "R3 width", minw, DIV);
        chk(maxw == DIV, "R3 width max", maxw, DIV);
        chk(ming == 2*DIV && maxg == 2*DIV, "R8 spacing", ming, 2*DIV);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R2 no restart", busy, 0);
        halt_n = 1'b1;
    endtask

    task automatic t_bus();
        clear_stats();
        @(negedge clk) bus_avail = 1'b0;
        start_xfer();
        repeat (50) @(negedge clk);
        chk(pulses == 0, "R5 bus hold", pulses, 0);
        chk(busy == 1'b1, "R5 still busy", busy, 1);
        bus_avail = 1'b1;
        wait_idle();
        chk(pulses == WORDS, "R5 resume count", pulses, WORDS);
    endtask

    task automatic t_word();
        clear_stats();
        @(negedge clk) word_rdy = 1'b0;
        start_xfer();
        repeat (50) @(negedge clk);
        chk(pulses == 0, "R7 word hold", pulses, 0);
        word_rdy = 1'b1;
        wait_idle();
        chk(pulses == WORDS, "R7 resume count", pulses, WORDS);
    endtask

    task automatic t_aux();
        int held;
        clear_stats();
        start_xfer();
        while (pulses < 3 || !wr_stb_n) @(negedge clk);
        aux_dis_n = 1'b0;
        held = pulses;
        repeat (60) @(negedge clk);
        chk(pulses == held, "R6 pause", pulses, held);
        chk(wr_stb_n == 1'b1, "R6 strobe idle", wr_stb_n, 1);
        aux_dis_n = 1'b1;
        wait_idle();
        chk(pulses == WORDS, "R6 resume count", pulses, WORDS);
        chk(minw == DIV && maxw == DIV, "R6 width", maxw, DIV);
    endtask

    task automatic t_xtn();
        @(negedge clk) xtn_pulse = 1'b1;
        @(negedge clk) xtn_pulse = 1'b0;
        chk(xtn_det == 1'b1, "R9 set", xtn_det, 1);
        repeat (10) @(negedge clk);
        chk(xtn_det == 1'b1, "R9 hold", xtn_det, 1);
        xtn_clr_n = 1'b0;
        @(negedge clk) xtn_clr_n = 1'b1;
        chk(xtn_det == 1'b0, "R10 clear", xtn_det, 0);
        xtn_pulse = 1'b1; xtn_clr_n = 1'b0;
        @(negedge clk) begin xtn_pulse = 1'b0; xtn_clr_n = 1'b1; end
        chk(xtn_det == 1'b1, "R10 set wins", xtn_det, 1);
    endtask

    task automatic t_cpurst();
        clear_stats();
        @(negedge clk) halt_n = 1'b0;
        while (pulses < 2) @(negedge clk);
        xtn_pulse = 1'b1;
        @(negedge clk) begin xtn_pulse = 1'b0; cpu_rst = 1'b1; end
        @(negedge clk) cpu_rst = 1'b0;
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(wr_stb_n == 1'b1, "R11 strobe", wr_stb_n, 1);
        chk(xtn_det == 1'b0, "R11 flag", xtn_det, 0);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R11 stays idle", busy, 0);
        halt_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_rst = 1'b0; halt_n = 1'b1; bus_avail = 1'b1;
        aux_dis_n = 1'b1; word_rdy = 1'b1; xtn_pulse = 1'b0; xtn_clr_n = 1'b1;
        pulses = 0; minw = 1000; maxw = 0; curw = 0; last_start = -1;
        ming = 1000; maxg = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_bus();
        t_word();
        t_aux();
        t_xtn();
        t_cpurst();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule : vtx_ctrl_bench